// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block watches a processor from outside and resets it when its software loses its timing. After the supply-good indication rises, the block holds the system in reset for a fixed power-on delay. It then repeats two phases. The first is a closed phase, in which servicing is forbidden. The second is an open phase, in which the processor must pull the service line low. A falling edge on the service line during the open phase counts as a correct service and starts a new closed phase. A falling edge during the closed phase counts as an early service. Running past the end of the open phase counts as a missed service. Either one produces a reset pulse of fixed length, and a new closed phase follows that pulse.

If the processor stays silent, the reset output becomes a steady square wave. The wave ends only when a service lands in an open phase, or when a new power-up sequence runs. A second output, the active-low system enable, stays off while reset is active. After any reset it also stays off until three correct services have arrived in a row. Critical actuators can therefore be gated on software that has restarted properly.

The service line is asynchronous. It passes through a synchronizer before the phase logic sees it. A supply-good drop shorter than the glitch limit is ignored. A longer drop forces reset and disable at once, and servicing is ignored until a full power-on delay has run again. All lengths are parameters in clock cycles.

Top module: `wdw_supervisor`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n` is 0 and `sys_en_n` is 1.
- R2: After `supply_ok` rises and stays high, `sys_rst_n` stays 0 for exactly POR_CYC+2 clock cycles and then rises. Service edges during that time have no effect.
- R3: A falling edge on `svc_line` in the open phase keeps `sys_rst_n` high and starts a fresh closed phase of CLOSED_CYC cycles.
- R4: A falling edge on `svc_line` in the closed phase drives `sys_rst_n` low for exactly PULSE_CYC cycles. A closed phase follows.
- R5: With no service, `sys_rst_n` repeats forever with a period of CLOSED_CYC+OPEN_CYC+PULSE_CYC cycles and a low time of PULSE_CYC cycles.
- R6: `sys_en_n` goes low only after GOOD_SERVICES (3) consecutive open-phase services since the last reset. It stays low on further correct services. An early or missed service returns it to 1.
- R7: `sys_en_n` is 1 in every cycle in which `sys_rst_n` is 0.
- R8: A low period on `supply_ok` shorter than GLITCH_CYC cycles changes neither output.
- R9: A low period on `supply_ok` of GLITCH_CYC cycles or more forces `sys_rst_n` to 0 and `sys_en_n` to 1 within GLITCH_CYC+1 cycles. A full power-on delay (R2) follows its return, and the enable count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| arst_n | input | 1 | Asynchronous chip reset, active low |
| supply_ok | input | 1 | Digital supply-good indication, high when the supply is valid |
| svc_line | input | 1 | Asynchronous service line; a falling edge is a service |
| sys_rst_n | output | 1 | System reset, active low |
| sys_en_n | output | 1 | System enable, active low |

## Verification
The properties assume that `supply_ok` is a clean level at the clock. They also assume that each low pulse on `svc_line` lasts long enough for the two synchronizer stages to capture it. The stimulus therefore changes every input only at falling clock edges. Each service pulse is held low for two full cycles and returned high well before the next one. Services are placed in the middle of a phase, away from the phase boundaries, so that the synchronizer latency cannot move a service into the other phase.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_POR    = 3'd1,
    PH_CLOSED = 3'd2,
    PH_OPEN   = 3'd3,
    PH_PULSE  = 3'd4
  } wdw_phase_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdw_svc_edge.sv
// Synchronizes the asynchronous service line and produces a one-cycle
// pulse on each falling edge seen after synchronization.
module wdw_svc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic svc_async,
  output logic svc_fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < int'(STAGES); g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= 1'b1;
          else         chain_q[0] <= svc_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) last_q <= 1'b1;
    else         last_q <= chain_q[STAGES-1];
  end

  assign svc_fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/wdw_supply_filter.sv
// Declares the supply lost once supply_ok has been low for GLITCH_CYC
// consecutive cycles; any high cycle restarts the count.
module wdw_supply_filter #(
  parameter int unsigned GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  output logic supply_lost
);

  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GLITCH_CYC);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                low_cnt_q <= LIMIT;
    else if (supply_ok)         low_cnt_q <= '0;
    else if (low_cnt_q != LIMIT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign supply_lost = (low_cnt_q == LIMIT);

endmodule

// File: rtl/wdw_window_fsm.sv
// Phase sequencer: off, power-on delay, closed, open, reset pulse.
module wdw_window_fsm
  import wdw_pkg::*;
#(
  parameter int unsigned CLOSED_CYC = 16,
  parameter int unsigned OPEN_CYC   = 16,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned POR_CYC    = 20
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_lost,
  input  logic       svc_fall,
  output wdw_phase_e phase,
  output logic       svc_good,
  output logic       svc_fault
);

  localparam int unsigned TMAX = max_of4(CLOSED_CYC, OPEN_CYC, PULSE_CYC, POR_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_POR    = TW'(POR_CYC - 1);
  localparam logic [TW-1:0] T_CLOSED = TW'(CLOSED_CYC - 1);
  localparam logic [TW-1:0] T_OPEN   = TW'(OPEN_CYC - 1);
  localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_CYC - 1);

  wdw_phase_e    phase_q, phase_d;
  logic [TW-1:0] timer_q, timer_d;
  logic          early, late;

  always_comb begin
    phase_d = phase_q;
    early   = 1'b0;
    late    = 1'b0;
    if (supply_lost) begin
      phase_d = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:    phase_d = PH_POR;
        PH_POR:    if (timer_q == T_POR) phase_d = PH_CLOSED;
        PH_CLOSED: begin
          if (svc_fall) begin
            phase_d = PH_PULSE;
            early   = 1'b1;
          end else if (timer_q == T_CLOSED) begin
            phase_d = PH_OPEN;
          end
        end
        PH_OPEN: begin
          if (svc_fall) begin
            phase_d = PH_CLOSED;
          end else if (timer_q == T_OPEN) begin
            phase_d = PH_PULSE;
            late    = 1'b1;
          end
        end
        PH_PULSE:  if (timer_q == T_PULSE) phase_d = PH_CLOSED;
        default:   phase_d = PH_OFF;
      endcase
    end
  end

  always_comb begin
    if (phase_d != phase_q || phase_q == PH_OFF) timer_d = '0;
    else                                         timer_d = timer_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_OFF;
      timer_q <= '0;
    end else begin
      phase_q <= phase_d;
      timer_q <= timer_d;
    end
  end

  assign phase     = phase_q;
  assign svc_good  = !supply_lost && phase_q == PH_OPEN && svc_fall;
  assign svc_fault = early | late;

endmodule

// File: rtl/wdw_enable_gate.sv
// Counts consecutive correct services, saturating at GOOD_SERVICES.
module wdw_enable_gate #(
  parameter int unsigned GOOD_SERVICES = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clear,
  input  logic svc_good,
  output logic ready
);

  localparam int unsigned CW = $clog2(GOOD_SERVICES + 1);
  localparam logic [CW-1:0] FULL = CW'(GOOD_SERVICES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                        run_q <= '0;
    else if (clear)                     run_q <= '0;
    else if (svc_good && run_q != FULL) run_q <= run_q + 1'b1;
  end

  assign ready = (run_q == FULL);

endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor
  import wdw_pkg::*;
#(
  parameter int unsigned CLOSED_CYC    = 16,
  parameter int unsigned OPEN_CYC      = 16,
  parameter int unsigned PULSE_CYC     = 4,
  parameter int unsigned POR_CYC       = 20,
  parameter int unsigned GLITCH_CYC    = 3,
  parameter int unsigned GOOD_SERVICES = 3,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic svc_line,
  output logic sys_rst_n,
  output logic sys_en_n
);

  logic       svc_fall;
  logic       supply_lost;
  wdw_phase_e phase;
  logic       svc_good;
  logic       svc_fault;
  logic       in_reset;
  logic       en_ready;

  wdw_svc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .arst_n    (arst_n),
    .svc_async (svc_line),
    .svc_fall  (svc_fall)
  );

  wdw_supply_filter #(.GLITCH_CYC(GLITCH_CYC)) u_supply (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_ok   (supply_ok),
    .supply_lost (supply_lost)
  );

  wdw_window_fsm #(
    .CLOSED_CYC (CLOSED_CYC),
    .OPEN_CYC   (OPEN_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .POR_CYC    (POR_CYC)
  ) u_fsm (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_lost (supply_lost),
    .svc_fall    (svc_fall),
    .phase       (phase),
    .svc_good    (svc_good),
    .svc_fault   (svc_fault)
  );

  assign in_reset = (phase == PH_OFF) || (phase == PH_POR) || (phase == PH_PULSE);

  wdw_enable_gate #(.GOOD_SERVICES(GOOD_SERVICES)) u_gate (
    .clk      (clk),
    .arst_n   (arst_n),
    .clear    (in_reset | svc_fault | supply_lost),
    .svc_good (svc_good),
    .ready    (en_ready)
  );

  assign sys_rst_n = ~in_reset;
  assign sys_en_n  = ~(en_ready & ~in_reset);

endmodule

// File: rtl/wdw_supervisor_chk.sv
module wdw_supervisor_chk #(
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned GLITCH_CYC = 3
) (
  input logic clk,
  input logic arst_n,
  input logic supply_ok,
  input logic sys_rst_n,
  input logic sys_en_n
);

  logic [15:0] rst_low_run;
  logic [15:0] supply_low_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_low_run    <= '0;
      supply_low_run <= '0;
    end else begin
      if (sys_rst_n)                   rst_low_run <= '0;
      else if (rst_low_run != 16'hFFFF) rst_low_run <= rst_low_run + 1'b1;
      if (supply_ok)                      supply_low_run <= '0;
      else if (supply_low_run != 16'hFFFF) supply_low_run <= supply_low_run + 1'b1;
    end
  end

  a_r7_en_off_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    !sys_rst_n |-> sys_en_n);

  a_r4_pulse_min_len: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> (rst_low_run >= 16'(PULSE_CYC)));

  a_r9_supply_loss: assert property (@(posedge clk) disable iff (!arst_n)
    (supply_low_run >= 16'(GLITCH_CYC + 1)) |-> (!sys_rst_n && sys_en_n));

  a_r6_enable_in_run: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sys_en_n) |-> (sys_rst_n && $past(sys_rst_n)));

  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> supply_ok);

endmodule

bind wdw_supervisor wdw_supervisor_chk #(
  .PULSE_CYC  (PULSE_CYC),
  .GLITCH_CYC (GLITCH_CYC)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .supply_ok (supply_ok),
  .sys_rst_n (sys_rst_n),
  .sys_en_n  (sys_en_n)
);

// File: tb/test_wdw_supervisor.sv
module test_wdw_supervisor;

  localparam int CL = 16;
  localparam int OP = 16;
  localparam int PL = 4;
  localparam int PR = 20;
  localparam int GL = 3;
  localparam int D_EARLY = CL / 2;
  localparam int D_VALID = CL + OP / 2 - 2;

  // vector: [3:2] kind (0 early, 1 valid, 2 none), [1] reset expected, [0] sys_en_n expected
  localparam logic [3:0] VEC [12] = '{
    4'b0101, 4'b0101, 4'b0100, 4'b0100,
    4'b0011, 4'b0101, 4'b0101, 4'b1011,
    4'b0101, 4'b0101, 4'b0100, 4'b1011
  };

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic svc_line = 1'b1;
  logic sys_rst_n, sys_en_n;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wdw_supervisor #(
    .CLOSED_CYC(CL), .OPEN_CYC(OP), .PULSE_CYC(PL), .POR_CYC(PR),
    .GLITCH_CYC(GL), .GOOD_SERVICES(3), .SYNC_STAGES(2)
  ) i_wdw_supervisor (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .svc_line(svc_line),
    .sys_rst_n(sys_rst_n), .sys_en_n(sys_en_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // from a phase reference, wait d cycles, then drive a two-cycle low pulse;
  // returns at the negedge where the result of the service is visible
  task automatic service_after(input int d);
    nwait(d);
    svc_line = 1'b0;
    nwait(2);
    svc_line = 1'b1;
    nwait(1);
  endtask

  task automatic low_run(output int n);
    n = 0;
    while (sys_rst_n == 1'b0 && n < 1000) begin
      n++;
      nwait(1);
    end
  endtask

  initial begin
    int n;
    int h;
    nwait(3);
    check("R1 rst", sys_rst_n, 0);
    check("R1 en", sys_en_n, 1);
    arst_n = 1'b1;
    nwait(2);
    // R2: power-on delay with a service attempt inside it
    supply_ok = 1'b1;
    nwait(5);
    svc_line = 1'b0;
    nwait(2);
    svc_line = 1'b1;
    nwait(PR + 1 - 7);
    check("R2 still low", sys_rst_n, 0);
    nwait(1);
    check("R2 release", sys_rst_n, 1);
    check("R6 en after por", sys_en_n, 1);

    for (int i = 0; i < 12; i++) begin
      logic [3:0] v;
      v = VEC[i];
      case (v[3:2])
        2'd0: begin
          service_after(D_EARLY);
          check("R4 early reset", sys_rst_n, 0);
          check("R7 en in reset", sys_en_n, 1);
          low_run(n);
          check("R4 pulse width", n, PL);
        end
        2'd1: begin
          service_after(D_VALID);
          check("R3 valid no reset", sys_rst_n, 1);
        end
        default: begin
          nwait(CL + OP);
          check("R5 timeout reset", sys_rst_n, 0);
          check("R7 en in timeout", sys_en_n, 1);
          low_run(n);
          check("R5 low width", n, PL);
        end
      endcase
      check("R6 enable vector", sys_en_n, int'(v[0]));
    end

    // R5: free-running train period, two periods
    for (int k = 0; k < 2; k++) begin
      h = 0;
      while (sys_rst_n == 1'b1 && h < 1000) begin
        h++;
        nwait(1);
      end
      low_run(n);
      check("R5 period", h + n, CL + OP + PL);
    end

    // regain enable
    for (int k = 0; k < 3; k++) service_after(D_VALID);
    check("R6 enable regained", sys_en_n, 0);

    // R8: short supply glitch
    supply_ok = 1'b0;
    nwait(GL - 1);
    supply_ok = 1'b1;
    check("R8 rst after glitch", sys_rst_n, 1);
    check("R8 en after glitch", sys_en_n, 0);
    service_after(D_VALID - (GL - 1));
    check("R8 window intact", sys_rst_n, 1);
    check("R8 en intact", sys_en_n, 0);

    // R9: long supply loss
    supply_ok = 1'b0;
    nwait(GL + 2);
    check("R9 rst forced", sys_rst_n, 0);
    check("R9 en forced", sys_en_n, 1);
    svc_line = 1'b0;
    nwait(2);
    svc_line = 1'b1;
    nwait(4);
    check("R9 service ignored", sys_rst_n, 0);
    supply_ok = 1'b1;
    nwait(PR + 1);
    check("R9 por low", sys_rst_n, 0);
    nwait(1);
    check("R9 por release", sys_rst_n, 1);
    check("R9 en count restarted", sys_en_n, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule